// File: doc/BRIEF.md
# Shared-Bus Time-Slot Audio Serial Port

This block is the slave end of a serial audio link that up to four codecs share. A frame-sync pulse starts every frame. A frame holds one, two or four equal sub-frames, and each codec owns exactly one of them, chosen by two strap inputs. The block runs on the serial bit clock.

In its owned sub-frame the block does three things:
- It shifts DAC samples and control words in from the serial input line.
- It shifts ADC samples and status words out on the serial output line.
- It drives the output line. Outside that window the output enable stays low, so another device can drive the line.

Two sub-frame sizes are supported:
- **Long mode:** the sub-frame carries four 16-bit words: two audio words and two control/status words.
- **Short mode:** the sub-frame carries only the two audio words.

Words received in the owned sub-frame reach holding registers at the end of the sub-frame, and a one-cycle strobe marks them. General-purpose input pins are sampled into the outgoing status word. General-purpose output pins follow the top bits of the first received control word, and they change only at a frame start.

Top module: `tdm_slot_port`

## Requirements
- R1: After reset, `sdout_oe`, `sdout`, `rx_valid`, `gpo` and all holding registers are zero. No bit is owned until the first `fsync` is sampled high.
- R2: `slot_count` sets the number of sub-frames: 0 gives 1, 1 gives 2, and 2 or 3 give 4. Sub-frame length is 64 bits in long mode (`long_mode`=1) and 32 bits in short mode. The strap value `slot_sel`=s owns frame bits s*len to s*len+len-1. A strap value not below the sub-frame count owns nothing.
- R3: Frame bit 0 occupies the clock cycle that follows the rising edge at which `fsync` is sampled high. Each later cycle carries the next bit.
- R4: Transmit order, all words MSB first:
  - Long mode: left ADC word, right ADC word, status word, `aux_stat`. The status word carries `gpi` in bits 15:12 and zeros below.
  - Short mode: only the two ADC words are sent.
  - All transmitted values are those present at the `fsync` sampling edge.
- R5: `sdout_oe` is high exactly during the owned bits, rising at the first and falling after the last. `sdout` is 0 whenever `sdout_oe` is low.
- R6: `sdin` is sampled at the rising edge that ends each owned bit. The words received in order are left DAC, right DAC, control word A and control word B. They appear on the holding outputs, with `rx_valid` high for exactly one cycle, in the cycle after the last owned bit.
- R7: Data on `sdin` outside the owned sub-frame changes no output. In short mode `ctrl_a` and `ctrl_b` keep their previous values.
- R8: `gpo` equals `ctrl_a[15:12]`, copied only at the edge that samples `fsync` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame start pulse |
| sdin | input | 1 | Serial data in (DAC and control) |
| sdout | output | 1 | Serial data out (ADC and status) |
| sdout_oe | output | 1 | Output drive enable, low means released |
| long_mode | input | 1 | 1: 64-bit sub-frames, 0: 32-bit sub-frames |
| slot_count | input | 2 | Sub-frames per frame code |
| slot_sel | input | 2 | Strap: owned sub-frame index |
| adc_left | input | 16 | Left ADC sample to send |
| adc_right | input | 16 | Right ADC sample to send |
| aux_stat | input | 16 | Second status word to send |
| gpi | input | 4 | General-purpose inputs into status word |
| dac_left | output | 16 | Received left DAC sample |
| dac_right | output | 16 | Received right DAC sample |
| ctrl_a | output | 16 | Received control word A |
| ctrl_b | output | 16 | Received control word B |
| rx_valid | output | 1 | One-cycle strobe for new received words |
| gpo | output | 4 | General-purpose outputs from control word A |

## Verification
A bit counter that is wrong by one position shows up at once. The enable window, and the transmitted bit in that window, move by one cycle in the very first owned sub-frame after `fsync`.

A fault in sub-frame decode or in the strap compare has two visible effects:
- The block drives or releases the line in another device's slot.
- The holding registers fill with a neighbour's words at the end of that frame.

A receive shift or capture fault appears on the holding outputs one cycle after the last owned bit. A stale or early control-to-pin copy is visible on `gpo` in the first cycle of the next frame.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

    localparam int MAX_SUBS = 4;

    // number of sub-frames selected by the two-bit count code
    function automatic logic [2:0] slot_count_of(input logic [1:0] code);
        logic [2:0] n;
        case (code)
            2'd0:    n = 3'd1;
            2'd1:    n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tdm_slot_tracker.sv
module tdm_slot_tracker
    import tdm_port_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fsync,
    input  logic                          long_mode,
    input  logic [1:0]                    slot_count,
    input  logic [1:0]                    slot_sel,
    output logic                          own_cur,
    output logic                          last_cur,
    output logic                          own_nxt,
    output logic [$clog2(4*WORD_W)-1:0]   bidx_nxt
);
    localparam int SUB_LONG  = 4 * WORD_W;
    localparam int SUB_SHORT = 2 * WORD_W;
    localparam int LOG_LONG  = $clog2(SUB_LONG);
    localparam int FRAME_MAX = MAX_SUBS * SUB_LONG;
    localparam int POS_W     = $clog2(FRAME_MAX + 1);
    localparam logic [POS_W-1:0] POS_SAT = POS_W'(FRAME_MAX);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } trk_t;

    trk_t s_d, s_q;
    logic [LOG_LONG-1:0] bidx_cur;

    function automatic logic [LOG_LONG-1:0] f_bidx(input logic [POS_W-1:0] p, input logic lm);
        return lm ? p[LOG_LONG-1:0] : {1'b0, p[LOG_LONG-2:0]};
    endfunction

    function automatic logic f_own(input logic [POS_W-1:0] p, input logic lm,
                                   input logic [1:0] cnt, input logic [1:0] sel);
        logic [POS_W-1:0] sub;
        sub = lm ? (p >> LOG_LONG) : (p >> (LOG_LONG - 1));
        return (sub == POS_W'(sel)) && ({1'b0, sel} < slot_count_of(cnt));
    endfunction

    function automatic logic f_last(input logic [POS_W-1:0] p, input logic lm);
        return lm ? (f_bidx(p, lm) == LOG_LONG'(SUB_LONG - 1))
                  : (f_bidx(p, lm) == LOG_LONG'(SUB_SHORT - 1));
    endfunction

    always_comb begin
        s_d = s_q;
        if (fsync) begin
            s_d.pos = '0;
        end else if (s_q.pos != POS_SAT) begin
            s_d.pos = s_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pos <= POS_SAT;
        end else begin
            s_q <= s_d;
        end
    end

    assign own_cur  = f_own(s_q.pos, long_mode, slot_count, slot_sel);
    assign last_cur = f_last(s_q.pos, long_mode);
    assign bidx_cur = f_bidx(s_q.pos, long_mode);
    assign own_nxt  = f_own(s_d.pos, long_mode, slot_count, slot_sel);
    assign bidx_nxt = f_bidx(s_d.pos, long_mode);

    // R2: ownership always begins on the first bit of a sub-frame
    a_r2_own_starts_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_cur) |-> (bidx_cur == '0));

endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path #(
    parameter int WORD_W = 16,
    parameter int GPI_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fsync,
    input  logic [WORD_W-1:0]             adc_left,
    input  logic [WORD_W-1:0]             adc_right,
    input  logic [WORD_W-1:0]             aux_stat,
    input  logic [GPI_W-1:0]              gpi,
    input  logic                          own_nxt,
    input  logic [$clog2(4*WORD_W)-1:0]   bidx_nxt,
    output logic                          sdout,
    output logic                          sdout_oe
);
    localparam int TOT   = 4 * WORD_W;
    localparam int LOG_T = $clog2(TOT);

    typedef struct packed {
        logic [TOT-1:0] tx;
        logic           sdout;
        logic           oe;
    } tx_t;

    tx_t s_d, s_q;
    logic [WORD_W-1:0] stat_word;
    logic [LOG_T-1:0]  rev;

    assign stat_word = WORD_W'(gpi) << (WORD_W - GPI_W);

    always_comb begin
        s_d = s_q;
        if (fsync) begin
            s_d.tx = {adc_left, adc_right, stat_word, aux_stat};
        end
        rev      = LOG_T'(TOT - 1) - bidx_nxt;
        s_d.oe    = own_nxt;
        s_d.sdout = own_nxt ? s_d.tx[rev] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sdout    = s_q.sdout;
    assign sdout_oe = s_q.oe;

    // R4: the outgoing word set only changes at a frame start
    a_r4_tx_latched: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fsync) |-> $stable(s_q.tx));

endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path #(
    parameter int WORD_W = 16,
    parameter int GPO_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fsync,
    input  logic               sdin,
    input  logic               long_mode,
    input  logic               own_cur,
    input  logic               last_cur,
    output logic [WORD_W-1:0]  dac_left,
    output logic [WORD_W-1:0]  dac_right,
    output logic [WORD_W-1:0]  ctrl_a,
    output logic [WORD_W-1:0]  ctrl_b,
    output logic               rx_valid,
    output logic [GPO_W-1:0]   gpo
);
    localparam int TOT = 4 * WORD_W;

    typedef struct packed {
        logic [TOT-1:0]    sh;
        logic [WORD_W-1:0] dl;
        logic [WORD_W-1:0] dr;
        logic [WORD_W-1:0] ca;
        logic [WORD_W-1:0] cb;
        logic              valid;
        logic [GPO_W-1:0]  gpo;
    } rx_t;

    rx_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (own_cur) begin
            s_d.sh = {s_q.sh[TOT-2:0], sdin};
            if (last_cur) begin
                if (long_mode) begin
                    {s_d.dl, s_d.dr, s_d.ca, s_d.cb} = s_d.sh;
                end else begin
                    {s_d.dl, s_d.dr} = s_d.sh[2*WORD_W-1:0];
                end
                s_d.valid = 1'b1;
            end
        end
        if (fsync) begin
            s_d.gpo = s_q.ca[WORD_W-1 -: GPO_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dac_left  = s_q.dl;
    assign dac_right = s_q.dr;
    assign ctrl_a    = s_q.ca;
    assign ctrl_b    = s_q.cb;
    assign rx_valid  = s_q.valid;
    assign gpo       = s_q.gpo;

    // R6: the capture strobe never lasts longer than one cycle
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |=> !s_q.valid);

    // R7: holding registers move only together with the strobe
    a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.valid |-> ($stable(s_q.dl) && $stable(s_q.dr) && $stable(s_q.ca) && $stable(s_q.cb)));

    // R8: output pins change only right after a frame sync
    a_r8_gpo_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fsync) |-> $stable(s_q.gpo));

endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port #(
    parameter int WORD_W = 16,
    parameter int GPI_W  = 4,
    parameter int GPO_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fsync,
    input  logic               sdin,
    output logic               sdout,
    output logic               sdout_oe,
    input  logic               long_mode,
    input  logic [1:0]         slot_count,
    input  logic [1:0]         slot_sel,
    input  logic [WORD_W-1:0]  adc_left,
    input  logic [WORD_W-1:0]  adc_right,
    input  logic [WORD_W-1:0]  aux_stat,
    input  logic [GPI_W-1:0]   gpi,
    output logic [WORD_W-1:0]  dac_left,
    output logic [WORD_W-1:0]  dac_right,
    output logic [WORD_W-1:0]  ctrl_a,
    output logic [WORD_W-1:0]  ctrl_b,
    output logic               rx_valid,
    output logic [GPO_W-1:0]   gpo
);
    localparam int BIDX_W = $clog2(4 * WORD_W);

    logic              own_cur, last_cur, own_nxt;
    logic [BIDX_W-1:0] bidx_nxt;

    tdm_slot_tracker #(.WORD_W(WORD_W)) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .long_mode  (long_mode),
        .slot_count (slot_count),
        .slot_sel   (slot_sel),
        .own_cur    (own_cur),
        .last_cur   (last_cur),
        .own_nxt    (own_nxt),
        .bidx_nxt   (bidx_nxt)
    );

    tdm_tx_path #(.WORD_W(WORD_W), .GPI_W(GPI_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .adc_left  (adc_left),
        .adc_right (adc_right),
        .aux_stat  (aux_stat),
        .gpi       (gpi),
        .own_nxt   (own_nxt),
        .bidx_nxt  (bidx_nxt),
        .sdout     (sdout),
        .sdout_oe  (sdout_oe)
    );

    tdm_rx_path #(.WORD_W(WORD_W), .GPO_W(GPO_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .sdin      (sdin),
        .long_mode (long_mode),
        .own_cur   (own_cur),
        .last_cur  (last_cur),
        .dac_left  (dac_left),
        .dac_right (dac_right),
        .ctrl_a    (ctrl_a),
        .ctrl_b    (ctrl_b),
        .rx_valid  (rx_valid),
        .gpo       (gpo)
    );

    // R6: a capture strobe follows a cycle in which the line was driven
    a_r6_strobe_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sdout_oe));

    // R5: releasing the line coincides with the end-of-slot capture
    a_r5_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdout_oe) |-> rx_valid);

endmodule

// File: tb/tdm_slot_port_bench.sv
module tdm_slot_port_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic        sdin = 1'b0;
    logic        long_mode = 1'b0;
    logic [1:0]  slot_count = 2'd0;
    logic [1:0]  slot_sel = 2'd0;
    logic [15:0] adc_left = '0, adc_right = '0, aux_stat = '0;
    logic [3:0]  gpi = '0;
    logic        sdout, sdout_oe, rx_valid;
    logic [15:0] dac_left, dac_right, ctrl_a, ctrl_b;
    logic [3:0]  gpo;

    int n_total = 0;
    int n_fail  = 0;

    logic [15:0] e_dl = '0, e_dr = '0, e_ca = '0, e_cb = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_slot_port u_tdm_slot_port (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .sdin(sdin),
        .sdout(sdout), .sdout_oe(sdout_oe), .long_mode(long_mode),
        .slot_count(slot_count), .slot_sel(slot_sel),
        .adc_left(adc_left), .adc_right(adc_right), .aux_stat(aux_stat), .gpi(gpi),
        .dac_left(dac_left), .dac_right(dac_right), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
        .rx_valid(rx_valid), .gpo(gpo)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic lm, input int code, input int sl);
        int nsub, len, total, vcount;
        logic owned, ob, eb;
        logic [63:0] sub_words [4];
        logic [63:0] txv;
        nsub  = (code == 0) ? 1 : (code == 1) ? 2 : 4;
        len   = lm ? 64 : 32;
        total = nsub * len;
        owned = (sl < nsub);
        vcount = 0;
        for (int s = 0; s < 4; s++) sub_words[s] = {$urandom, $urandom};
        @(negedge clk);
        long_mode  = lm;
        slot_count = 2'(code);
        slot_sel   = 2'(sl);
        adc_left   = 16'($urandom);
        adc_right  = 16'($urandom);
        aux_stat   = 16'($urandom);
        gpi        = 4'($urandom);
        txv        = {adc_left, adc_right, gpi, 12'h000, aux_stat};
        fsync = 1'b1;
        sdin  = 1'b0;
        for (int k = 0; k <= total; k++) begin
            @(negedge clk);
            if (k == 0) begin
                fsync = 1'b0;
                check(gpo == e_ca[15:12], "R8 gpo at frame start", 64'(gpo), 64'(e_ca[15:12]));
                // R4: inputs changed after the sync edge must not reach this frame
                adc_left  = ~adc_left;
                adc_right = ~adc_right;
                aux_stat  = ~aux_stat;
                gpi       = ~gpi;
            end
            ob = owned && (k >= sl*len) && (k < sl*len + len) && (k < total);
            check(sdout_oe == ob, "R2 R3 R5 output enable window", 64'(sdout_oe), 64'(ob));
            if (ob) begin
                eb = txv[63 - (k - sl*len)];
                check(sdout == eb, "R4 transmitted bit", 64'(sdout), 64'(eb));
            end else begin
                check(sdout == 1'b0, "R5 idle output low", 64'(sdout), 64'd0);
            end
            if (rx_valid) vcount++;
            if (k < total) sdin = sub_words[k / len][len - 1 - (k % len)];
            else           sdin = 1'b1;
        end
        if (owned) begin
            if (lm) {e_dl, e_dr, e_ca, e_cb} = sub_words[sl];
            else    {e_dl, e_dr} = sub_words[sl][31:0];
        end
        check(vcount == (owned ? 1 : 0), "R6 strobe count", 64'(vcount), owned ? 64'd1 : 64'd0);
        check({dac_left, dac_right} == {e_dl, e_dr}, "R6 R7 audio holding",
              64'({dac_left, dac_right}), 64'({e_dl, e_dr}));
        check({ctrl_a, ctrl_b} == {e_ca, e_cb}, "R6 R7 control holding",
              64'({ctrl_a, ctrl_b}), 64'({e_ca, e_cb}));
        // idle gap: nothing driven, nothing captured
        repeat (3) begin
            @(negedge clk);
            check(sdout_oe == 1'b0, "R5 idle gap enable", 64'(sdout_oe), 64'd0);
            check(rx_valid == 1'b0, "R7 idle gap strobe", 64'(rx_valid), 64'd0);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and no ownership before the first sync
        repeat (5) begin
            @(negedge clk);
            sdin = ~sdin;
            check(sdout_oe == 1'b0, "R1 enable after reset", 64'(sdout_oe), 64'd0);
            check(sdout == 1'b0, "R1 sdout after reset", 64'(sdout), 64'd0);
            check(rx_valid == 1'b0, "R1 strobe after reset", 64'(rx_valid), 64'd0);
        end
        check(gpo == 4'd0, "R1 gpo after reset", 64'(gpo), 64'd0);
        check({dac_left, dac_right, ctrl_a, ctrl_b} == 64'd0, "R1 holding after reset",
              {dac_left, dac_right, ctrl_a, ctrl_b}, 64'd0);
        for (int m = 1; m >= 0; m--)
            for (int c = 0; c < 4; c++)
                for (int s = 0; s < 4; s++)
                    run_frame(m[0], c, s);
        // repeat long mode so the short-mode-captured state feeds R8 again
        run_frame(1'b1, 2, 1);
        run_frame(1'b1, 0, 0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule